// File: doc/BRIEF.md
# External Interrupt Edge Controller

This block collects eleven external interrupt inputs and turns each selected pin edge into a latched request for the processor. The inputs are one non-maskable line, four request lines that each have their own vector and their own enable, and six wake-up lines. The wake-up lines each keep their own flag and edge choice, but they share one vector and one group enable.

Every input is synchronised with two flops and then compared with its previous synchronised sample. The edge chosen by software (rising or falling) sets a pending flag. Software clears a flag by writing 0 to its bit. The block drives one NMI request, four IRQ requests, one combined wake-up request and an encoded index of the most urgent pending request.

The register port is a single 3-bit address with a write strobe and a combinational read. All registers reset to 0. A 1 in an edge-select bit means rising, and a 0 means falling.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A pin change driven before clock edge k is visible as a set flag, and as a request when enabled, after clock edge k+2, and not after edge k+1.
- R2: The NMI flag (address 5 bit 0) sets on the edge chosen by address 0 bit 0, with no enable or function bit involved, and `nmi_req` follows that flag.
- R3: IRQ line n uses its own edge-select bit at address 0 bit n+1, independent of the other lines.
- R4: The IRQ n flag (address 5 bit n+1) sets only while its function-select bit (address 2 bit n) is 1.
- R5: `irq_req[n]` is 1 only when the IRQ n flag and its enable (address 4 bit n) are both 1; the flag still latches while the enable is 0.
- R6: Wake-up line m has its own edge-select bit (address 1 bit m), function-select bit (address 3 bit m) and flag (address 6 bit m).
- R7: `wkp_req` is the OR of the six wake-up flags gated by the single group enable at address 4 bit 4.
- R8: Writing 0 to a set flag bit clears it, and writing 1 leaves it unchanged. When a qualified edge arrives in the same cycle as the clearing write, the flag stays set.
- R9: `vec_idx` gives the most urgent active request: 0 for NMI, 1 to 4 for IRQ0 to IRQ3, and 5 for wake-up. `vec_valid` is 1 exactly when some request is active.
- R10: Changing an edge-select bit while the pin is steady sets no flag.
- R11: After reset every register reads 0 and no request or valid output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| irq_pin | input | 4 | Individually vectored interrupt pins |
| wkp_pin | input | 6 | Wake-up interrupt pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address, for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| nmi_req | output | 1 | Non-maskable request |
| irq_req | output | 4 | Per-line maskable requests |
| wkp_req | output | 1 | Combined wake-up request |
| vec_valid | output | 1 | Some request is active |
| vec_idx | output | 3 | Index of the most urgent active request |

## Verification
The assertions check several rules on every cycle. A flag may rise only after a qualified edge, and a disabled line never requests. A qualified edge always leaves its flag set in the next cycle, even against a clear. NMI always wins the index, and an edge is only ever reported when the synchronised history changed. Only the bench scenarios can show the following: the exact three-edge latency, the effect of each edge-select polarity, which register bit drives which line, how a partial write clears flags, and the full priority order as requests come and go.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [2:0] {
    REG_EDGE_A = 3'd0,   // bit0 nmi polarity, bits N_IRQ:1 irq polarity
    REG_EDGE_B = 3'd1,   // wake polarity
    REG_FUNC_A = 3'd2,   // irq function select
    REG_FUNC_B = 3'd3,   // wake function select
    REG_ENABLE = 3'd4,   // irq enables, then wake group enable
    REG_FLAG_A = 3'd5,   // bit0 nmi flag, bits N_IRQ:1 irq flags
    REG_FLAG_B = 3'd6    // wake flags
  } eic_reg_e;

  // polarity 1 = rising, 0 = falling; uses only sampled history
  function automatic logic edge_hit(input logic cur, input logic prev, input logic pol);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

  // pending flag next state: a new set beats a clear
  function automatic logic flag_next(input logic flag, input logic set, input logic clr);
    return set | (flag & ~clr);
  endfunction

endpackage

// File: rtl/eic_edge.sv
module eic_edge
  import ext_irq_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] pol,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev,
  output logic [W-1:0] hit
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      cur  <= '0;
      prev <= '0;
    end else begin
      meta <= pin;
      cur  <= meta;
      prev <= cur;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    assign hit[i] = edge_hit(cur[i], prev[i], pol[i]);
  end
endmodule

// File: rtl/eic_flags.sv
module eic_flags
  import ext_irq_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flag
);
  logic [W-1:0] flag_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign flag_d[i] = flag_next(flag[i], set[i], clr[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= '0;
    else        flag <= flag_d;
  end
endmodule

// File: rtl/eic_prio.sv
module eic_prio #(
  parameter int N_IRQ = 4,
  parameter int VW    = 3
) (
  input  logic             nmi,
  input  logic [N_IRQ-1:0] irq,
  input  logic             wkp,
  output logic             valid,
  output logic [VW-1:0]    idx
);
  // lowest priority first, each stronger source overwrites
  always_comb begin
    idx   = '0;
    valid = nmi | (|irq) | wkp;
    if (wkp) idx = VW'(N_IRQ + 1);
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (irq[i]) idx = VW'(i + 1);
    end
    if (nmi) idx = '0;
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int N_IRQ = 4,
  parameter int N_WKP = 6,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_pin,
  input  logic [N_IRQ-1:0] irq_pin,
  input  logic [N_WKP-1:0] wkp_pin,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             nmi_req,
  output logic [N_IRQ-1:0] irq_req,
  output logic             wkp_req,
  output logic             vec_valid,
  output logic [$clog2(N_IRQ+2)-1:0] vec_idx
);
  localparam int VW    = $clog2(N_IRQ + 2);
  localparam int PAD_A = DW - N_IRQ - 1;
  localparam int PAD_B = DW - N_WKP;

  // configuration state
  logic             nmi_pol;
  logic [N_IRQ-1:0] irq_pol, irq_func, irq_en;
  logic [N_WKP-1:0] wkp_pol, wkp_func;
  logic             wkp_en;

  // named internal events
  logic             nmi_cur, nmi_prev, nmi_hit, nmi_clr, nmi_flag;
  logic [N_IRQ-1:0] irq_cur, irq_prev, irq_hit, irq_set, irq_clr, irq_flag;
  logic [N_WKP-1:0] wkp_cur, wkp_prev, wkp_hit, wkp_set, wkp_clr, wkp_flag;
  logic             wr_flag_a, wr_flag_b;
  logic             unused_wd;

  assign unused_wd = ^reg_wdata;

  // ---------------- register writes ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_pol  <= 1'b0;
      irq_pol  <= '0;
      irq_func <= '0;
      irq_en   <= '0;
      wkp_pol  <= '0;
      wkp_func <= '0;
      wkp_en   <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        REG_EDGE_A: begin
          nmi_pol <= reg_wdata[0];
          irq_pol <= reg_wdata[N_IRQ:1];
        end
        REG_EDGE_B: wkp_pol  <= reg_wdata[N_WKP-1:0];
        REG_FUNC_A: irq_func <= reg_wdata[N_IRQ-1:0];
        REG_FUNC_B: wkp_func <= reg_wdata[N_WKP-1:0];
        REG_ENABLE: begin
          irq_en <= reg_wdata[N_IRQ-1:0];
          wkp_en <= reg_wdata[N_IRQ];
        end
        default: ;
      endcase
    end
  end

  // ---------------- edge detection ----------------
  eic_edge #(.W(1)) u_nmi_edge (
    .clk(clk), .rst_n(rst_n), .pin(nmi_pin), .pol(nmi_pol),
    .cur(nmi_cur), .prev(nmi_prev), .hit(nmi_hit)
  );

  eic_edge #(.W(N_IRQ)) u_irq_edge (
    .clk(clk), .rst_n(rst_n), .pin(irq_pin), .pol(irq_pol),
    .cur(irq_cur), .prev(irq_prev), .hit(irq_hit)
  );

  eic_edge #(.W(N_WKP)) u_wkp_edge (
    .clk(clk), .rst_n(rst_n), .pin(wkp_pin), .pol(wkp_pol),
    .cur(wkp_cur), .prev(wkp_prev), .hit(wkp_hit)
  );

  // ---------------- pending flags ----------------
  assign wr_flag_a = reg_we && (reg_addr == REG_FLAG_A);
  assign wr_flag_b = reg_we && (reg_addr == REG_FLAG_B);

  assign nmi_clr = wr_flag_a & ~reg_wdata[0];
  assign irq_clr = {N_IRQ{wr_flag_a}} & ~reg_wdata[N_IRQ:1];
  assign wkp_clr = {N_WKP{wr_flag_b}} & ~reg_wdata[N_WKP-1:0];

  assign irq_set = irq_hit & irq_func;
  assign wkp_set = wkp_hit & wkp_func;

  eic_flags #(.W(1)) u_nmi_flag (
    .clk(clk), .rst_n(rst_n), .set(nmi_hit), .clr(nmi_clr), .flag(nmi_flag)
  );

  eic_flags #(.W(N_IRQ)) u_irq_flag (
    .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr), .flag(irq_flag)
  );

  eic_flags #(.W(N_WKP)) u_wkp_flag (
    .clk(clk), .rst_n(rst_n), .set(wkp_set), .clr(wkp_clr), .flag(wkp_flag)
  );

  // ---------------- requests ----------------
  assign nmi_req = nmi_flag;
  assign irq_req = irq_flag & irq_en;
  assign wkp_req = (|wkp_flag) & wkp_en;

  eic_prio #(.N_IRQ(N_IRQ), .VW(VW)) u_prio (
    .nmi(nmi_req), .irq(irq_req), .wkp(wkp_req),
    .valid(vec_valid), .idx(vec_idx)
  );

  // ---------------- read mux ----------------
  always_comb begin
    case (reg_addr)
      REG_EDGE_A: reg_rdata = {{PAD_A{1'b0}}, irq_pol, nmi_pol};
      REG_EDGE_B: reg_rdata = {{PAD_B{1'b0}}, wkp_pol};
      REG_FUNC_A: reg_rdata = {{PAD_A{1'b0}}, 1'b0, irq_func};
      REG_FUNC_B: reg_rdata = {{PAD_B{1'b0}}, wkp_func};
      REG_ENABLE: reg_rdata = {{PAD_A{1'b0}}, wkp_en, irq_en};
      REG_FLAG_A: reg_rdata = {{PAD_A{1'b0}}, irq_flag, nmi_flag};
      REG_FLAG_B: reg_rdata = {{PAD_B{1'b0}}, wkp_flag};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int N_IRQ = 4,
  parameter int N_WKP = 6,
  parameter int VW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nmi_hit,
  input logic             nmi_req,
  input logic [N_IRQ-1:0] irq_cur,
  input logic [N_IRQ-1:0] irq_prev,
  input logic [N_IRQ-1:0] irq_hit,
  input logic [N_IRQ-1:0] irq_func,
  input logic [N_IRQ-1:0] irq_flag,
  input logic [N_IRQ-1:0] irq_en,
  input logic [N_IRQ-1:0] irq_req,
  input logic [N_WKP-1:0] wkp_hit,
  input logic [N_WKP-1:0] wkp_func,
  input logic [N_WKP-1:0] wkp_flag,
  input logic             wkp_en,
  input logic             wkp_req,
  input logic             vec_valid,
  input logic [VW-1:0]    vec_idx
);
  // R2: an NMI edge always produces a request next cycle
  a_r2_nmi_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_hit |=> nmi_req);

  // R7: group enable low blocks the wake request
  a_r7_wkp_group: assert property (@(posedge clk) disable iff (!rst_n)
    !wkp_en |-> !wkp_req);

  // R9: NMI owns index 0
  a_r9_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> (vec_valid && vec_idx == '0));

  // R9: valid reflects any active request
  a_r9_valid: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid == (nmi_req || (|irq_req) || wkp_req));

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    // R4: flag rises only after a qualified edge
    a_r4_func_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag[i]) |-> $past(irq_hit[i] & irq_func[i]));
    // R5: disabled line never requests
    a_r5_mask: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en[i] |-> !irq_req[i]);
    // R8: qualified edge wins over a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_hit[i] & irq_func[i]) |=> irq_flag[i]);
    // R10: no edge without a change in sampled history
    a_r10_history: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_cur[i] == irq_prev[i]) |-> !irq_hit[i]);
  end

  for (genvar m = 0; m < N_WKP; m++) begin : g_wkp
    // R6: wake flag rises only after a qualified edge
    a_r6_func_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wkp_flag[m]) |-> $past(wkp_hit[m] & wkp_func[m]));
  end
endmodule

bind ext_irq_ctrl eic_checker #(.N_IRQ(N_IRQ), .N_WKP(N_WKP), .VW($clog2(N_IRQ+2))) u_chk (
  .clk(clk), .rst_n(rst_n),
  .nmi_hit(nmi_hit), .nmi_req(nmi_req),
  .irq_cur(irq_cur), .irq_prev(irq_prev), .irq_hit(irq_hit),
  .irq_func(irq_func), .irq_flag(irq_flag), .irq_en(irq_en), .irq_req(irq_req),
  .wkp_hit(wkp_hit), .wkp_func(wkp_func), .wkp_flag(wkp_flag),
  .wkp_en(wkp_en), .wkp_req(wkp_req),
  .vec_valid(vec_valid), .vec_idx(vec_idx)
);

// File: tb/sim_ext_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctrl;
  localparam logic [2:0] A_EDGE_A = 3'd0, A_EDGE_B = 3'd1, A_FUNC_A = 3'd2,
                         A_FUNC_B = 3'd3, A_ENABLE = 3'd4, A_FLAG_A = 3'd5,
                         A_FLAG_B = 3'd6;

  // {line[1:0], pol, func, en, dir(1=rising edge applied), exp_flag, exp_req}
  localparam logic [7:0] VEC [8] = '{
    8'b00_1_1_1_1_1_1,
    8'b01_0_1_1_0_1_1,
    8'b10_1_1_0_1_1_0,
    8'b11_0_1_1_1_0_0,
    8'b00_1_0_1_1_0_0,
    8'b10_0_1_1_0_1_1,
    8'b11_1_1_1_1_1_1,
    8'b01_1_1_1_0_0_0
  };

  logic       clk = 0;
  logic       rst_n = 0;
  logic       nmi_pin = 0;
  logic [3:0] irq_pin = '0;
  logic [5:0] wkp_pin = '0;
  logic       reg_we = 0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       nmi_req, wkp_req, vec_valid;
  logic [3:0] irq_req;
  logic [2:0] vec_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  ext_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_pin(irq_pin), .wkp_pin(wkp_pin),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nmi_req(nmi_req), .irq_req(irq_req), .wkp_req(wkp_req),
    .vec_valid(vec_valid), .vec_idx(vec_idx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(A_FLAG_A, 8'h00);
    wr(A_FLAG_B, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      chk("R11 register reset", d, 0);
    end
    chk("R11 nmi_req", nmi_req, 0);
    chk("R11 irq_req", irq_req, 0);
    chk("R11 wkp_req", wkp_req, 0);
    chk("R11 vec_valid", vec_valid, 0);

    // R1 latency: irq0 rising, enabled
    wr(A_FUNC_A, 8'h01); wr(A_ENABLE, 8'h01); wr(A_EDGE_A, 8'h02);
    @(negedge clk) irq_pin[0] = 1;
    repeat (2) @(posedge clk);
    @(negedge clk) chk("R1 not yet after two edges", irq_req[0], 0);
    @(posedge clk);
    @(negedge clk) chk("R1 request after third edge", irq_req[0], 1);
    irq_pin[0] = 0;
    settle(); clear_all();

    // R3 R4 R5 vector table
    for (int k = 0; k < 8; k++) begin
      logic [7:0] v;
      int ln;
      v  = VEC[k];
      ln = int'(v[7:6]);
      wr(A_FUNC_A, 8'(v[4]) << ln);
      wr(A_ENABLE, 8'(v[3]) << ln);
      wr(A_EDGE_A, 8'(v[5]) << (ln + 1));
      irq_pin[ln] = ~v[2];
      settle(); clear_all();
      @(negedge clk) irq_pin[ln] = v[2];
      repeat (3) @(posedge clk);
      @(negedge clk);
      rd(A_FLAG_A, d);
      chk("R3 R4 flag row", d[ln+1], v[1]);
      chk("R5 request row", irq_req[ln], v[0]);
      if (v[0]) chk("R9 index row", vec_idx, ln + 1);
      irq_pin[ln] = 0;
      settle(); clear_all();
    end

    // R2 NMI falling, no enable anywhere
    wr(A_ENABLE, 8'h00); wr(A_EDGE_A, 8'h00);
    nmi_pin = 1; settle();
    chk("R2 rising ignored when falling chosen", nmi_req, 0);
    nmi_pin = 0; settle();
    chk("R2 nmi falling sets", nmi_req, 1);
    chk("R9 nmi index", vec_idx, 0);
    wr(A_FLAG_A, 8'hFE);
    chk("R8 nmi cleared by zero", nmi_req, 0);
    wr(A_EDGE_A, 8'h01);
    nmi_pin = 1; settle();
    chk("R2 nmi rising sets", nmi_req, 1);
    clear_all();

    // R10 polarity toggles with steady pin
    wr(A_EDGE_A, 8'h00); wr(A_EDGE_A, 8'h01); settle();
    rd(A_FLAG_A, d);
    chk("R10 polarity change sets nothing", d[0], 0);
    nmi_pin = 0; settle();
    chk("R2 falling ignored when rising chosen", nmi_req, 0);

    // R8 write-one and set-wins on irq1
    wr(A_FUNC_A, 8'h02); wr(A_ENABLE, 8'h02); wr(A_EDGE_A, 8'h04);
    irq_pin[1] = 1; settle();
    wr(A_FLAG_A, 8'hFF);
    chk("R8 writing one keeps flag", irq_req[1], 1);
    irq_pin[1] = 0; settle();
    @(negedge clk) irq_pin[1] = 1;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk) begin reg_we = 1; reg_addr = A_FLAG_A; reg_wdata = 8'h00; end
    @(posedge clk);
    @(negedge clk) reg_we = 0;
    chk("R8 set wins over clear", irq_req[1], 1);
    wr(A_FLAG_A, 8'h00);
    chk("R8 clear removes flag", irq_req[1], 0);
    irq_pin[1] = 0; settle(); clear_all();

    // R6 R7 wake lines
    wr(A_ENABLE, 8'h00); wr(A_FUNC_B, 8'h00); wr(A_EDGE_B, 8'h08);
    wkp_pin[3] = 1; settle();
    rd(A_FLAG_B, d);
    chk("R6 function off blocks flag", d, 0);
    wkp_pin[3] = 0; settle();
    wr(A_FUNC_B, 8'h09);
    wkp_pin[3] = 1; settle();
    rd(A_FLAG_B, d);
    chk("R6 wake3 rising flag", d, 8'h08);
    chk("R7 group enable off", wkp_req, 0);
    wr(A_ENABLE, 8'h10);
    chk("R7 group enable on", wkp_req, 1);
    chk("R9 wake index", vec_idx, 5);
    wkp_pin[0] = 1; settle();
    wkp_pin[0] = 0; settle();
    rd(A_FLAG_B, d);
    chk("R6 wake0 falling flag", d, 8'h09);
    wr(A_FLAG_B, 8'hF7);
    rd(A_FLAG_B, d);
    chk("R8 partial clear", d, 8'h01);
    chk("R7 remaining flag requests", wkp_req, 1);

    // R9 priority order (wake0 still pending and enabled)
    wr(A_FUNC_A, 8'h0F); wr(A_EDGE_A, 8'h1E); wr(A_ENABLE, 8'h1F);
    irq_pin[2] = 1; settle();
    chk("R9 irq2 over wake", vec_idx, 3);
    irq_pin[1] = 1; settle();
    chk("R9 irq1 over irq2", vec_idx, 2);
    nmi_pin = 1; settle();
    nmi_pin = 0; settle();
    chk("R9 nmi over all", vec_idx, 0);
    wr(A_FLAG_A, 8'h1E);
    chk("R9 back to irq1", vec_idx, 2);
    wr(A_FLAG_A, 8'hFB);
    chk("R9 back to irq2", vec_idx, 3);
    wr(A_FLAG_A, 8'h00);
    chk("R9 back to wake", vec_idx, 5);
    wr(A_FLAG_B, 8'h00);
    chk("R9 nothing valid", vec_valid, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule